// File: doc/BRIEF.md
# Host Memory Request Router

This block takes each memory request from the host bus and decides where it should go. There are four possible outcomes: system DRAM, the downstream I/O link, the integrated graphics function, or immediate termination with an abort. The decision depends on the address, a small set of programmable windows, the requester's identity, the CPU mode (SMM or not) and a write-back attribute. Most requests keep their address unchanged. A request that hits the enabled high SMM window and is allowed through is moved onto the legacy SMM DRAM area at `000A_0000h`–`000B_FFFFh`, keeping its offset.

Software programs the block through a write-only port. The port sets the graphics window bases, the top of low DRAM and an enable for the high SMM window. Requests come in with a valid/ready pair. Each accepted request produces one registered result one cycle later. That result stays stable until the consumer takes it.

Top module: `hostaddr_decoder`

## Requirements
- R1: After reset the output is not valid, the high SMM window is disabled, every graphics window is disabled and top of low DRAM is zero, so every request is routed to the link (dest code 1) with its address unchanged.
- R2: Addresses `FFE0_0000h`–`FFFF_FFFFh` always go to the link (dest 1) with the address unchanged, even if a graphics window or the SMM window overlaps them.
- R3: Addresses `FEC0_0000h`–`FECF_FFFFh` (interrupt controller units, one per 4 KB page) always go to the link (dest 1) with the address unchanged. This range never goes to any other destination.
- R4: With the SMM window enabled, a CPU request (origin 0) in `FEDA_0000h`–`FEDB_FFFFh` issued in SMM mode goes to DRAM (dest 0) at `000A_0000h` plus its address bits [16:0].
- R5: With the SMM window enabled, a non-SMM CPU request in that window is remapped as in R4 only if it is a write carrying the write-back attribute. Otherwise it is terminated: dest 3, abort 1, address unchanged.
- R6: With the SMM window enabled, any request in that window whose origin is not the CPU (1 = PCIe, 2 = link, 3 = other) is terminated with dest 3 and abort 1.
- R7: With the SMM window disabled, addresses in that window decode like any other address, through the graphics, DRAM and link rules.
- R8: Three graphics windows route to dest 2 with the address unchanged: register window (512 KB), translation-table window (1 MB) and aperture (256 MB). Each window is enabled by its first base write. The base bits below the window size are ignored. Where windows overlap, priority is register > table > aperture.
- R9: An address below top of low DRAM goes to DRAM (dest 0) unchanged. Top of low DRAM has 1 MB granularity, and its low 20 written bits are ignored. Any address that matches no rule goes to the link.
- R10: Register writes use `cfg_sel`: 0 register-window base, 1 aperture base, 2 table base, 3 top of low DRAM, 4 SMM window enable (bit 0). A write takes effect for requests accepted from the next cycle on.
- R11: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high when the output is empty or `out_ready` is high. The result appears one cycle after acceptance and is held stable while `out_ready` is low.
- R12: `out_abort` is 1 exactly when `out_dest` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wb | input | 1 | Write-back or implicit write-back attribute |
| req_smm | input | 1 | CPU is in SMM mode |
| req_origin | input | 2 | Requester: 0 CPU, 1 PCIe, 2 link, 3 other |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_dest | output | 2 | 0 DRAM, 1 link, 2 graphics, 3 terminated |
| out_addr | output | 32 | Final (possibly remapped) address |
| out_abort | output | 1 | Request terminated |

## Verification
Any wrong state shows at the ports on the very next result, because every decision is made from the current configuration and the request in one step.
- A stale or mis-latched window base or DRAM limit sends boundary addresses to the wrong destination.
- A stuck SMM enable flips the window addresses between the remap, abort and plain-decode outcomes.

Randomized requests are mixed across every address region, requester and mode, and each result is compared with an independent bench model. Directed cases cover overlap priority, the exact DRAM limit and holding the output under back-pressure.

// File: rtl/hdec_pkg.sv
package hdec_pkg;

    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        DST_DRAM = 2'd0,
        DST_LINK = 2'd1,
        DST_GFX  = 2'd2,
        DST_NONE = 2'd3
    } dest_e;

    localparam logic [1:0] ORG_CPU = 2'd0;

    localparam logic [2:0] SEL_MMIO  = 3'd0;
    localparam logic [2:0] SEL_APER  = 3'd1;
    localparam logic [2:0] SEL_GTT   = 3'd2;
    localparam logic [2:0] SEL_TOLUD = 3'd3;
    localparam logic [2:0] SEL_HSEG  = 3'd4;

    // Fixed architectural regions
    localparam logic [10:0] BOOT_TAG  = 11'h7FF;   // FFE0_0000 .. FFFF_FFFF
    localparam logic [11:0] APIC_TAG  = 12'hFEC;   // FEC0_0000 .. FECF_FFFF
    localparam logic [14:0] HSEG_TAG  = 15'h7F6D;  // FEDA_0000 .. FEDB_FFFF
    localparam logic [14:0] SMRAM_TAG = 15'h0005;  // 000A_0000 .. 000B_FFFF

    typedef struct packed {
        logic [ADDR_W-1:0] mmio_base;
        logic [ADDR_W-1:0] aper_base;
        logic [ADDR_W-1:0] gtt_base;
        logic [ADDR_W-1:0] tolud;
        logic              mmio_on;
        logic              aper_on;
        logic              gtt_on;
        logic              hseg_on;
    } cfg_t;

    typedef struct packed {
        dest_e             dest;
        logic [ADDR_W-1:0] addr;
        logic              abort;
    } result_t;

endpackage

// File: rtl/hdec_cfg_regs.sv
module hdec_cfg_regs
    import hdec_pkg::*;
#(
    parameter int MMIO_BITS  = 19,
    parameter int APER_BITS  = 28,
    parameter int GTT_BITS   = 20,
    parameter int TOLUD_BITS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [2:0]        sel_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output cfg_t              cfg_o
);

    localparam logic [ADDR_W-1:0] ONE        = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] MMIO_MASK  = ~((ONE << MMIO_BITS)  - ONE);
    localparam logic [ADDR_W-1:0] APER_MASK  = ~((ONE << APER_BITS)  - ONE);
    localparam logic [ADDR_W-1:0] GTT_MASK   = ~((ONE << GTT_BITS)   - ONE);
    localparam logic [ADDR_W-1:0] TOLUD_MASK = ~((ONE << TOLUD_BITS) - ONE);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (sel_i)
                SEL_MMIO: begin
                    cfg_d.mmio_base = wdata_i & MMIO_MASK;
                    cfg_d.mmio_on   = 1'b1;
                end
                SEL_APER: begin
                    cfg_d.aper_base = wdata_i & APER_MASK;
                    cfg_d.aper_on   = 1'b1;
                end
                SEL_GTT: begin
                    cfg_d.gtt_base = wdata_i & GTT_MASK;
                    cfg_d.gtt_on   = 1'b1;
                end
                SEL_TOLUD: cfg_d.tolud   = wdata_i & TOLUD_MASK;
                SEL_HSEG:  cfg_d.hseg_on = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R10: the enable write lands in the following cycle
    assert_hseg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_HSEG) |=> (cfg_q.hseg_on == $past(wdata_i[0])));

    // R8: a written base never keeps bits below its window size
    assert_gtt_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_GTT) |=> ((cfg_q.gtt_base & ~GTT_MASK) == '0) && cfg_q.gtt_on);

endmodule

// File: rtl/hdec_classify.sv
module hdec_classify
    import hdec_pkg::*;
#(
    parameter int MMIO_BITS = 19,
    parameter int APER_BITS = 28,
    parameter int GTT_BITS  = 20
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              write_i,
    input  logic              wb_i,
    input  logic              smm_i,
    input  logic [1:0]        origin_i,
    input  cfg_t              cfg_i,
    output result_t           res_o
);

    localparam int NWIN = 3;   // index order is priority: register, table, aperture
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] gbase [NWIN];
    logic [NWIN-1:0]   gon;
    logic [NWIN-1:0]   ghit;

    assign gbase[0] = cfg_i.mmio_base;
    assign gbase[1] = cfg_i.gtt_base;
    assign gbase[2] = cfg_i.aper_base;
    assign gon      = {cfg_i.aper_on, cfg_i.gtt_on, cfg_i.mmio_on};

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        localparam int WB = (i == 0) ? MMIO_BITS : (i == 1) ? GTT_BITS : APER_BITS;
        localparam logic [ADDR_W-1:0] WMASK = ~((ONE << WB) - ONE);
        assign ghit[i] = gon[i] && ((addr_i & WMASK) == gbase[i]);
    end

    logic boot_hit, apic_hit, hseg_hit, dram_hit, from_cpu, wb_write;

    assign boot_hit = (addr_i[31:21] == BOOT_TAG);
    assign apic_hit = (addr_i[31:20] == APIC_TAG);
    assign hseg_hit = cfg_i.hseg_on && (addr_i[31:17] == HSEG_TAG);
    assign dram_hit = (addr_i < cfg_i.tolud);
    assign from_cpu = (origin_i == ORG_CPU);
    assign wb_write = write_i && wb_i;

    always_comb begin
        res_o.dest  = DST_LINK;
        res_o.addr  = addr_i;
        res_o.abort = 1'b0;
        if (boot_hit || apic_hit) begin
            res_o.dest = DST_LINK;
        end else if (hseg_hit) begin
            if (from_cpu && (smm_i || wb_write)) begin
                res_o.dest = DST_DRAM;
                res_o.addr = {SMRAM_TAG, addr_i[16:0]};
            end else begin
                res_o.dest  = DST_NONE;
                res_o.abort = 1'b1;
            end
        end else if (|ghit) begin
            res_o.dest = DST_GFX;
        end else if (dram_hit) begin
            res_o.dest = DST_DRAM;
        end
    end

endmodule

// File: rtl/hdec_out_stage.sv
module hdec_out_stage
    import hdec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid_i,
    output logic    in_ready_o,
    input  result_t in_res_i,
    output logic    out_valid_o,
    input  logic    out_ready_i,
    output result_t out_res_o
);

    typedef struct packed {
        logic    vld;
        result_t res;
    } st_t;

    st_t st_d, st_q;

    assign in_ready_o = !st_q.vld || out_ready_i;

    always_comb begin
        st_d = st_q;
        if (out_ready_i) st_d.vld = 1'b0;
        if (in_valid_i && in_ready_o) begin
            st_d.vld = 1'b1;
            st_d.res = in_res_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign out_res_o   = st_q.res;

    // R11: an accepted request shows up one cycle later
    assert_accept_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> out_valid_o);

    // R11: a stalled result does not move
    assert_hold_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_res_o)));

endmodule

// File: rtl/hostaddr_decoder.sv
module hostaddr_decoder
    import hdec_pkg::*;
#(
    parameter int MMIO_BITS  = 19,
    parameter int APER_BITS  = 28,
    parameter int GTT_BITS   = 20,
    parameter int TOLUD_BITS = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic        req_wb,
    input  logic        req_smm,
    input  logic [1:0]  req_origin,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [1:0]  out_dest,
    output logic [31:0] out_addr,
    output logic        out_abort
);

    cfg_t    cfg;
    result_t dec_res;
    result_t out_res;

    hdec_cfg_regs #(
        .MMIO_BITS(MMIO_BITS), .APER_BITS(APER_BITS),
        .GTT_BITS(GTT_BITS), .TOLUD_BITS(TOLUD_BITS)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel),
        .wdata_i(cfg_wdata), .cfg_o(cfg)
    );

    hdec_classify #(
        .MMIO_BITS(MMIO_BITS), .APER_BITS(APER_BITS), .GTT_BITS(GTT_BITS)
    ) cls_i (
        .addr_i(req_addr), .write_i(req_write), .wb_i(req_wb), .smm_i(req_smm),
        .origin_i(req_origin), .cfg_i(cfg), .res_o(dec_res)
    );

    hdec_out_stage out_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(req_valid), .in_ready_o(req_ready), .in_res_i(dec_res),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_res_o(out_res)
    );

    assign out_dest  = out_res.dest;
    assign out_addr  = out_res.addr;
    assign out_abort = out_res.abort;

    // R3: interrupt-controller addresses only ever leave toward the link
    assert_apic_to_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_addr[31:20] == 12'hFEC) |-> (out_dest == 2'd1 && !out_abort));

    // R2: boot region only ever leaves toward the link
    assert_boot_to_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_addr[31:21] == 11'h7FF) |-> (out_dest == 2'd1));

    // R12: abort flag and terminated code agree
    assert_abort_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_abort == (out_dest == 2'd3)));

    // R1: nothing is presented in the cycle after reset ends
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

endmodule

// File: tb/hostaddr_decoder_tb_top.sv
module hostaddr_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_wb = 1'b0;
    logic        req_smm = 1'b0;
    logic [1:0]  req_origin = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [1:0]  out_dest;
    logic [31:0] out_addr;
    logic        out_abort;

    int n_chk = 0;
    int n_fail = 0;

    // bench copy of the programmed state, from the register rules
    logic [31:0] m_mmio = '0, m_aper = '0, m_gtt = '0, m_tolud = '0;
    bit m_mmio_on = 0, m_aper_on = 0, m_gtt_on = 0, m_hseg = 0;

    always #5 clk = ~clk;

    hostaddr_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wb(req_wb),
        .req_smm(req_smm), .req_origin(req_origin), .out_valid(out_valid),
        .out_ready(out_ready), .out_dest(out_dest), .out_addr(out_addr),
        .out_abort(out_abort)
    );

    // returns {dest[1:0], addr[31:0], abort}
    function automatic logic [34:0] model(input logic [31:0] a, input bit w, input bit wb,
                                          input bit smm, input logic [1:0] org);
        if (a >= 32'hFFE0_0000) return {2'd1, a, 1'b0};
        if (a >= 32'hFEC0_0000 && a <= 32'hFECF_FFFF) return {2'd1, a, 1'b0};
        if (m_hseg && a >= 32'hFEDA_0000 && a <= 32'hFEDB_FFFF) begin
            if (org == 2'd0 && (smm || (w && wb)))
                return {2'd0, 32'h000A_0000 + (a - 32'hFEDA_0000), 1'b0};
            return {2'd3, a, 1'b1};
        end
        if (m_mmio_on && a >= m_mmio && a - m_mmio < 32'h0008_0000) return {2'd2, a, 1'b0};
        if (m_gtt_on  && a >= m_gtt  && a - m_gtt  < 32'h0010_0000) return {2'd2, a, 1'b0};
        if (m_aper_on && a >= m_aper && a - m_aper < 32'h1000_0000) return {2'd2, a, 1'b0};
        if (a < m_tolud) return {2'd0, a, 1'b0};
        return {2'd1, a, 1'b0};
    endfunction

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0: begin m_mmio  = d & 32'hFFF8_0000; m_mmio_on = 1; end
            3'd1: begin m_aper  = d & 32'hF000_0000; m_aper_on = 1; end
            3'd2: begin m_gtt   = d & 32'hFFF0_0000; m_gtt_on  = 1; end
            3'd3: m_tolud = d & 32'hFFF0_0000;
            3'd4: m_hseg  = d[0];
            default: ;
        endcase
    endtask

    task automatic apply(input logic [31:0] a, input bit w, input bit wb, input bit smm,
                         input logic [1:0] org, input string req);
        logic [34:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wb = wb;
        req_smm = smm; req_origin = org;
        e = model(a, w, wb, smm, org);
        @(negedge clk);
        req_valid = 1'b0;
        n_chk++;
        if (!out_valid || out_dest != e[34:33] || out_addr != e[32:1] || out_abort != e[0]) begin
            n_fail++;
            $display("FAIL %s addr=%h: got v=%0b dest=%0d addr=%h abort=%0b, expected v=1 dest=%0d addr=%h abort=%0b",
                     req, a, out_valid, out_dest, out_addr, out_abort, e[34:33], e[32:1], e[0]);
        end
    endtask

    task automatic check(input bit ok, input string req, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: v=%0b rdy=%0b dest=%0d addr=%h abort=%0b",
                     req, what, out_valid, req_ready, out_dest, out_addr, out_abort);
        end
    endtask

    function automatic logic [31:0] pick_addr();
        case ($urandom % 8)
            0: return 32'hFFE0_0000 | ($urandom & 32'h001F_FFFF);
            1: return 32'hFEC0_0000 | ($urandom & 32'h000F_FFFF);
            2, 3: return 32'hFEDA_0000 | ($urandom & 32'h0001_FFFF);
            4: return 32'hD000_0000 | ($urandom & 32'h003F_FFFF);
            5: return 32'hC000_0000 | ($urandom & 32'h0FFF_FFFF);
            6: return 32'h7FF0_0000 | ($urandom & 32'h001F_FFFF);
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] hold_addr;
        logic [1:0]  hold_dest;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && req_ready, "R1", "idle after reset");
        // R1 / R7: nothing programmed, everything to link, window unremapped
        apply(32'h0000_1000, 0, 0, 0, 2'd0, "R1");
        apply(32'hFEDA_0040, 1, 1, 0, 2'd0, "R1_R7");
        apply(32'hC000_0000, 0, 0, 0, 2'd0, "R1");

        // R8: aperture over the top region; R2 and R3 keep priority
        cfg_write(3'd1, 32'hF123_4567);
        apply(32'hFFF0_0010, 0, 0, 0, 2'd0, "R2");
        apply(32'hFEC3_0000, 1, 0, 0, 2'd1, "R3");
        apply(32'hF800_0000, 0, 0, 0, 2'd0, "R8");
        apply(32'hFEDB_0000, 0, 0, 1, 2'd0, "R7");

        // R8: register window over table window, register wins; low bits dropped
        cfg_write(3'd2, 32'hD000_0ABC);
        cfg_write(3'd0, 32'hD007_1234);
        apply(32'hD007_FFFC, 0, 0, 0, 2'd0, "R8");
        apply(32'hD008_0000, 0, 0, 0, 2'd0, "R8");
        apply(32'hD010_0000, 0, 0, 0, 2'd0, "R8");

        // final map for random phase
        cfg_write(3'd1, 32'hC000_0000);
        cfg_write(3'd2, 32'hD010_0000);
        cfg_write(3'd3, 32'h800F_FFFF);
        apply(32'h7FFF_FFFC, 0, 0, 0, 2'd0, "R9");
        apply(32'h8000_0000, 0, 0, 0, 2'd0, "R9");

        // R4 R5 R6 with the window on
        cfg_write(3'd4, 32'h1);
        apply(32'hFEDA_0000, 0, 0, 1, 2'd0, "R4");
        apply(32'hFEDB_FFFC, 1, 0, 1, 2'd0, "R4");
        apply(32'hFEDA_1230, 1, 1, 0, 2'd0, "R5");
        apply(32'hFEDA_1230, 0, 1, 0, 2'd0, "R5");
        apply(32'hFEDA_1230, 1, 0, 0, 2'd0, "R5");
        apply(32'hFEDA_2000, 1, 1, 1, 2'd1, "R6");
        apply(32'hFEDA_2000, 0, 0, 1, 2'd2, "R6");
        apply(32'hFEDC_0000, 0, 0, 1, 2'd0, "R4");
        cfg_write(3'd4, 32'h0);
        apply(32'hFEDA_2000, 0, 0, 0, 2'd1, "R7");
        cfg_write(3'd7, 32'h1);   // unused select changes nothing
        apply(32'hFEDA_2000, 0, 0, 0, 2'd1, "R10");

        // R11: stall, hold, refuse, release
        @(negedge clk);
        out_ready = 1'b0;
        apply(32'hFEDA_0000, 0, 0, 0, 2'd0, "R11");
        hold_addr = out_addr; hold_dest = out_dest;
        req_valid = 1'b1; req_addr = 32'h0000_0100; req_origin = 2'd0;
        @(negedge clk);
        check(out_valid && !req_ready && out_addr == hold_addr && out_dest == hold_dest,
              "R11", "held while stalled");
        req_valid = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check(!out_valid && req_ready, "R11", "drained after release");

        // random mix
        for (int i = 0; i < 600; i++) begin
            if (i % 150 == 0) cfg_write(3'd4, {31'd0, ~m_hseg});
            apply(pick_addr(), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                  "R2_R9_random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule